// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by searching a hashed page table held in memory. A request carries a virtual segment identifier, a page index, an abbreviated page index, an access type, the 12-bit page offset, the table base address and the hash mask. The walker forms a primary hash and then a complemented secondary hash. Each hash selects a group of eight entries, and the walker examines the entries of a group one at a time.

When an entry matches, the walker reads the entry's mapping word. It sets the referenced and changed bits as the access type requires and stores the word back, except when the access is a side-effect-free probe. It then returns the physical address together with the updated mapping word, which a translation buffer can use as fill data. If neither group holds a matching entry, it reports a fault. Every memory access is a single 32-bit word exchanged over a request/acknowledge port. Page-table words are big-endian in memory and the port is little-endian, so the walker swaps bytes in both directions.

Top module: `hptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req`, `done` and `fill_valid` are 0.
- R2: The primary hash is `req_vsid[18:0]` XOR the zero-extended `req_pidx`. The secondary hash is its bitwise complement. A group's address is ((hash AND `tbl_mask`) shifted left by 6) OR `tbl_base`. Entry k (k = 0..7) of a group lies at the group address plus 8k. All eight entries of the primary group are examined in ascending order before any entry of the secondary group.
- R3: In memory, a word is stored with its most significant byte at the lowest address. On the port, `mem_rdata[7:0]` and `mem_wdata[7:0]` carry the byte at `mem_addr`. The first word of an entry (the tag word) holds valid in bit 31, the segment identifier in bits 30:7, the hash-select flag in bit 6 and the abbreviated page index in bits 5:0.
- R4: An entry matches only when it is valid, its segment identifier and abbreviated index equal the request, and its hash-select flag is 0 in the primary group and 1 in the secondary group.
- R5: On a match, the mapping word is read at the entry address plus 4. It holds the real page number in bits 31:12, the referenced bit in bit 8 and the changed bit in bit 7. Access codes are 0 probe, 1 read, 2 write and 3 fetch. Read, write and fetch set the referenced bit. Only write sets the changed bit. All other bits are kept.
- R6: For a non-probe hit, the updated mapping word is written once to the entry address plus 4. A probe writes nothing.
- R7: A hit ends with a one-cycle `done` pulse, `fault` = 0, `paddr` = {real page number, `req_off`} and `pte_word` = the updated mapping word.
- R8: If neither group has a match, the walk makes exactly 16 tag-word reads and no write, and ends with `done` and `fault` both 1.
- R9: `fill_valid` pulses together with `done` only for a hit that is not a probe.
- R10: A request is taken only while `req_ready` is 1, which is only when idle. `req_valid` and the request fields are ignored during a walk.
- R11: The memory port allows one outstanding access. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. Each acknowledge completes exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New walk requested |
| req_ready | output | 1 | Walker idle, request is taken |
| req_vsid | input | 24 | Virtual segment identifier |
| req_pidx | input | 16 | Page index |
| req_api | input | 6 | Abbreviated page index |
| req_acc | input | 2 | Access type: 0 probe, 1 read, 2 write, 3 fetch |
| req_off | input | 12 | Page offset |
| tbl_base | input | 32 | Page-table base address |
| tbl_mask | input | 19 | Hash mask |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write |
| mem_addr | output | 32 | Word address (byte-granular) |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | No matching entry (with `done`) |
| paddr | output | 32 | Physical address (with `done`) |
| pte_word | output | 32 | Updated mapping word for the fill |
| fill_valid | output | 1 | Buffer fill strobe |

## Verification
The bench places an exact-looking decoy in every spot where a careless walker would stop: an invalid entry, an entry whose hash-select flag is wrong for the group, and an entry whose index differs. A design that ignored the flag or the valid bit would return the decoy's page number and show too few reads. Hits at the last secondary slot and under a narrow mask test the slot loop bound and the masking, and a walker that got either wrong would fault or read from the wrong group. Probe and write accesses expose a walker that writes back on a probe or sets the wrong status bit. All memory is kept in big-endian byte order, so a walker that skipped the byte swap would miss every entry.

// File: rtl/hptw_pkg.sv
package hptw_pkg;
    localparam int WORD_W = 32;
    localparam int VSID_W = 24;
    localparam int API_W  = 6;
    localparam int RPN_W  = 20;
    localparam int OFF_W  = 12;
    localparam int PIDX_W = 16;

    typedef enum logic [1:0] {
        ACC_PROBE = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_FETCH = 2'd3
    } acc_e;

    // tag word, as seen after byte swap
    typedef struct packed {
        logic              valid;
        logic [VSID_W-1:0] vsid;
        logic              hsel;
        logic [API_W-1:0]  api;
    } tag_word_t;

    // mapping word, as seen after byte swap
    typedef struct packed {
        logic [RPN_W-1:0] rpn;
        logic [2:0]       rsv_hi;
        logic             ref_bit;
        logic             chg_bit;
        logic [3:0]       attr;
        logic             rsv_lo;
        logic [1:0]       prot;
    } map_word_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_TAG  = 3'd1,
        S_MAP  = 3'd2,
        S_WB   = 3'd3,
        S_FIN  = 3'd4
    } walk_state_e;
endpackage

// File: rtl/hptw_bswap.sv
module hptw_bswap #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end
endmodule

// File: rtl/hptw_group_addr.sv
module hptw_group_addr #(
    parameter int ADDR_W    = 32,
    parameter int HASH_W    = 19,
    parameter int PIDX_W    = 16,
    parameter int GRP_SHIFT = 6
) (
    input  logic [HASH_W-1:0] vsid_lo,
    input  logic [PIDX_W-1:0] pidx,
    input  logic [HASH_W-1:0] mask,
    input  logic [ADDR_W-1:0] base,
    input  logic              secondary,
    output logic [ADDR_W-1:0] grp_addr
);
    logic [HASH_W-1:0] h_pri;
    logic [HASH_W-1:0] h_sel;

    assign h_pri    = vsid_lo ^ HASH_W'(pidx);
    assign h_sel    = secondary ? ~h_pri : h_pri;
    assign grp_addr = (ADDR_W'(h_sel & mask) << GRP_SHIFT) | base;
endmodule

// File: rtl/hptw_entry_match.sv
module hptw_entry_match
    import hptw_pkg::*;
(
    input  tag_word_t         tag,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              secondary,
    output logic              hit
);
    assign hit = tag.valid && (tag.hsel == secondary)
              && (tag.vsid == vsid) && (tag.api == api);
endmodule

// File: rtl/hptw_walker.sv
module hptw_walker
    import hptw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int HASH_W      = 19,
    parameter int ENTRIES     = 8,
    parameter int ENTRY_BYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VSID_W-1:0]   req_vsid,
    input  logic [PIDX_W-1:0]   req_pidx,
    input  logic [API_W-1:0]    req_api,
    input  logic [1:0]          req_acc,
    input  logic [OFF_W-1:0]    req_off,
    input  logic [ADDR_W-1:0]   tbl_base,
    input  logic [HASH_W-1:0]   tbl_mask,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                done,
    output logic                fault,
    output logic [RPN_W+OFF_W-1:0] paddr,
    output logic [WORD_W-1:0]   pte_word,
    output logic                fill_valid
);
    localparam int IDX_W       = $clog2(ENTRIES);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int GRP_SHIFT   = $clog2(ENTRIES * ENTRY_BYTES);
    localparam int MAP_OFS     = ENTRY_BYTES / 2;
    localparam int PA_W        = RPN_W + OFF_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        walk_state_e         st;
        logic [IDX_W-1:0]    idx;
        logic                sec;
        logic [VSID_W-1:0]   vsid;
        logic [PIDX_W-1:0]   pidx;
        logic [API_W-1:0]    api;
        acc_e                acc;
        logic [OFF_W-1:0]    off;
        logic [ADDR_W-1:0]   base;
        logic [HASH_W-1:0]   mask;
        map_word_t           map;
        logic                fault;
        logic [PA_W-1:0]     pa;
    } regs_t;

    regs_t r_d, r_q;

    // ---------------- datapath helpers ----------------
    logic [ADDR_W-1:0] grp_addr;
    logic [ADDR_W-1:0] entry_addr;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] wr_word;
    tag_word_t         rd_tag;
    map_word_t         rd_map;
    map_word_t         upd_map;
    logic              slot_hit;

    hptw_group_addr #(
        .ADDR_W   (ADDR_W),
        .HASH_W   (HASH_W),
        .PIDX_W   (PIDX_W),
        .GRP_SHIFT(GRP_SHIFT)
    ) u_grp (
        .vsid_lo  (r_q.vsid[HASH_W-1:0]),
        .pidx     (r_q.pidx),
        .mask     (r_q.mask),
        .base     (r_q.base),
        .secondary(r_q.sec),
        .grp_addr (grp_addr)
    );

    hptw_bswap #(.W(WORD_W)) u_swap_rd (
        .din (mem_rdata),
        .dout(rd_word)
    );

    assign wr_word = r_q.map;

    hptw_bswap #(.W(WORD_W)) u_swap_wr (
        .din (wr_word),
        .dout(mem_wdata)
    );

    assign rd_tag = rd_word;
    assign rd_map = rd_word;

    hptw_entry_match u_match (
        .tag      (rd_tag),
        .vsid     (r_q.vsid),
        .api      (r_q.api),
        .secondary(r_q.sec),
        .hit      (slot_hit)
    );

    assign entry_addr = grp_addr + ADDR_W'({r_q.idx, {ENTRY_SHIFT{1'b0}}});

    // status bit update by access type
    always_comb begin
        upd_map = rd_map;
        if (r_q.acc != ACC_PROBE) begin
            upd_map.ref_bit = 1'b1;
        end
        if (r_q.acc == ACC_WRITE) begin
            upd_map.chg_bit = 1'b1;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.st    = S_TAG;
                    r_d.idx   = '0;
                    r_d.sec   = 1'b0;
                    r_d.vsid  = req_vsid;
                    r_d.pidx  = req_pidx;
                    r_d.api   = req_api;
                    r_d.acc   = acc_e'(req_acc);
                    r_d.off   = req_off;
                    r_d.base  = tbl_base;
                    r_d.mask  = tbl_mask;
                    r_d.fault = 1'b0;
                end
            end
            S_TAG: begin
                if (mem_ack) begin
                    if (slot_hit) begin
                        r_d.st = S_MAP;
                    end else if (r_q.idx == LAST_IDX) begin
                        r_d.idx = '0;
                        if (r_q.sec) begin
                            r_d.fault = 1'b1;
                            r_d.st    = S_FIN;
                        end else begin
                            r_d.sec = 1'b1;
                        end
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            S_MAP: begin
                if (mem_ack) begin
                    r_d.map = upd_map;
                    r_d.pa  = {rd_map.rpn, r_q.off};
                    r_d.st  = (r_q.acc == ACC_PROBE) ? S_FIN : S_WB;
                end
            end
            S_WB: begin
                if (mem_ack) begin
                    r_d.st = S_FIN;
                end
            end
            S_FIN: begin
                r_d.st = S_IDLE;
            end
            default: begin
                r_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // ---------------- outputs ----------------
    assign req_ready  = (r_q.st == S_IDLE);
    assign mem_req    = (r_q.st == S_TAG) || (r_q.st == S_MAP) || (r_q.st == S_WB);
    assign mem_we     = (r_q.st == S_WB);
    assign mem_addr   = (r_q.st == S_TAG) ? entry_addr : entry_addr + ADDR_W'(MAP_OFS);
    assign done       = (r_q.st == S_FIN);
    assign fault      = r_q.fault;
    assign paddr      = r_q.pa;
    assign pte_word   = r_q.map;
    assign fill_valid = done && !r_q.fault && (r_q.acc != ACC_PROBE);

    // ---------------- assertions ----------------
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    p_fill_hit_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (done && !fault));

    p_probe_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (r_q.acc != ACC_PROBE));

    p_wb_ref_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[16]);

    p_fault_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> !$past(mem_we));
endmodule

// File: tb/tb_hptw_walker.sv
`timescale 1ns/1ps
module tb_hptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vsid = '0;
    logic [15:0] req_pidx = '0;
    logic [5:0]  req_api = '0;
    logic [1:0]  req_acc = '0;
    logic [11:0] req_off = '0;
    logic [31:0] tbl_base = '0;
    logic [18:0] tbl_mask = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, fault, fill_valid;
    logic [31:0] paddr, pte_word;

    always #2 clk = ~clk;

    hptw_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vsid(req_vsid), .req_pidx(req_pidx), .req_api(req_api),
        .req_acc(req_acc), .req_off(req_off),
        .tbl_base(tbl_base), .tbl_mask(tbl_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .paddr(paddr),
        .pte_word(pte_word), .fill_valid(fill_valid)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // ---------------- byte memory model ----------------
    logic [7:0] mem [int unsigned];
    int lat = 0;
    int wait_cnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [31:0] first_rd_addr;
    logic [31:0] last_wr_addr;

    function automatic logic [7:0] rb(input int unsigned a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [31:0] rdw(input int unsigned a);
        return {rb(a), rb(a + 1), rb(a + 2), rb(a + 3)};
    endfunction

    task automatic put_word(input int unsigned a, input logic [31:0] w);
        mem[a]     = w[31:24];
        mem[a + 1] = w[23:16];
        mem[a + 2] = w[15:8];
        mem[a + 3] = w[7:0];
    endtask

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt < lat) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    for (int k = 0; k < 4; k++) mem[mem_addr + k] = mem_wdata[8*k +: 8];
                    wr_cnt++;
                    last_wr_addr = mem_addr;
                end else begin
                    mem_rdata = {rb(mem_addr + 3), rb(mem_addr + 2), rb(mem_addr + 1), rb(mem_addr)};
                    if (rd_cnt == 0) first_rd_addr = mem_addr;
                    rd_cnt++;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] tagw(input bit v, input logic [23:0] vs, input bit h, input logic [5:0] a);
        return {v, vs, h, a};
    endfunction

    function automatic logic [31:0] mapw(input logic [19:0] rpn, input bit r, input bit c, input logic [1:0] pp);
        return {rpn, 3'b000, r, c, 4'b0000, 1'b0, pp};
    endfunction

    function automatic logic [31:0] grp(input logic [23:0] v, input logic [15:0] p,
                                        input logic [18:0] m, input logic [31:0] b, input bit sec);
        logic [18:0] h;
        h = v[18:0] ^ {3'b000, p};
        if (sec) h = ~h;
        return ({13'b0, h & m} << 6) | b;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic        w_fault, w_fill;
    logic [31:0] w_pa, w_pte;
    int          ready_seen;

    task automatic walk(input logic [23:0] v, input logic [15:0] p, input logic [5:0] a,
                        input logic [1:0] acc, input logic [11:0] off,
                        input logic [31:0] b, input logic [18:0] m, input bit intrude);
        int cyc;
        rd_cnt = 0; wr_cnt = 0; ready_seen = 0;
        @(negedge clk);
        req_vsid = v; req_pidx = p; req_api = a; req_acc = acc; req_off = off;
        tbl_base = b; tbl_mask = m; req_valid = 1'b1;
        @(negedge clk);
        if (intrude) begin
            req_vsid = ~v; req_api = ~a; req_acc = 2'd0; req_off = ~off;
        end else begin
            req_valid = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 3000) begin
            if (req_ready) ready_seen++;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        if (cyc >= 3000) chk("R7", "walk completes", 32'd0, 32'd1);
        w_fault = fault; w_pa = paddr; w_pte = pte_word; w_fill = fill_valid;
        @(negedge clk);
        chk("R7", "done lasts one cycle", {31'b0, done}, 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "req_ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R1", "mem_req after reset", {31'b0, mem_req}, 32'd0);
        chk("R1", "done after reset", {31'b0, done}, 32'd0);
        chk("R1", "fill_valid after reset", {31'b0, fill_valid}, 32'd0);
    endtask

    localparam logic [23:0] VA = 24'h123456;
    localparam logic [15:0] PA_ = 16'h0ABC;
    localparam logic [5:0]  AA = 6'h2D;
    localparam logic [31:0] BASE = 32'h0010_0000;
    localparam logic [18:0] MASK = 19'h003FF;

    task automatic setup_primary();
        logic [31:0] g;
        mem.delete();
        g = grp(VA, PA_, MASK, BASE, 0);
        put_word(g + 8, tagw(1, VA, 0, AA ^ 6'h01));
        put_word(g + 24, tagw(1, VA, 0, AA));
        put_word(g + 28, mapw(20'h5A5A5, 0, 0, 2'b10));
    endtask

    task automatic t_primary_read();
        logic [31:0] g;
        setup_primary();
        g = grp(VA, PA_, MASK, BASE, 0);
        walk(VA, PA_, AA, 2'd1, 12'h123, BASE, MASK, 0);
        chk("R2", "first tag address", first_rd_addr, g);
        chk("R4", "reads to slot 3 hit", rd_cnt, 5);
        chk("R7", "fault on hit", {31'b0, w_fault}, 32'd0);
        chk("R7", "paddr", w_pa, 32'h5A5A5123);
        chk("R5", "read sets R only", w_pte, mapw(20'h5A5A5, 1, 0, 2'b10));
        chk("R6", "one write-back", wr_cnt, 1);
        chk("R6", "write-back address", last_wr_addr, g + 28);
        chk("R3", "memory word big-endian after write", rdw(g + 28), mapw(20'h5A5A5, 1, 0, 2'b10));
        chk("R9", "fill on read hit", {31'b0, w_fill}, 32'd1);
    endtask

    task automatic t_secondary_write();
        logic [23:0] v;
        logic [15:0] p;
        logic [5:0] a;
        logic [31:0] g1, g2;
        v = 24'hABCDEF; p = 16'h1357; a = 6'h15;
        mem.delete();
        g1 = grp(v, p, MASK, BASE, 0);
        g2 = grp(v, p, MASK, BASE, 1);
        put_word(g1 + 16, tagw(1, v, 1, a));
        put_word(g1 + 20, mapw(20'h11111, 0, 0, 2'b00));
        put_word(g2 + 40, tagw(1, v, 0, a));
        put_word(g2 + 44, mapw(20'h22222, 0, 0, 2'b00));
        put_word(g2 + 48, tagw(1, v, 1, a));
        put_word(g2 + 52, mapw(20'h3C3C3, 0, 0, 2'b01));
        walk(v, p, a, 2'd2, 12'hABC, BASE, MASK, 0);
        chk("R4", "hash-select decoys skipped, paddr", w_pa, 32'h3C3C3ABC);
        chk("R2", "reads for secondary slot 6", rd_cnt, 16);
        chk("R5", "write sets R and C", w_pte, mapw(20'h3C3C3, 1, 1, 2'b01));
        chk("R6", "write-back address secondary", last_wr_addr, g2 + 52);
        chk("R6", "memory after write", rdw(g2 + 52), mapw(20'h3C3C3, 1, 1, 2'b01));
        chk("R4", "primary decoy mapping untouched", rdw(g1 + 20), mapw(20'h11111, 0, 0, 2'b00));
    endtask

    task automatic t_probe();
        logic [31:0] g;
        setup_primary();
        g = grp(VA, PA_, MASK, BASE, 0);
        walk(VA, PA_, AA, 2'd0, 12'h001, BASE, MASK, 0);
        chk("R6", "probe writes nothing", wr_cnt, 0);
        chk("R6", "probe leaves memory", rdw(g + 28), mapw(20'h5A5A5, 0, 0, 2'b10));
        chk("R5", "probe word unchanged", w_pte, mapw(20'h5A5A5, 0, 0, 2'b10));
        chk("R7", "probe paddr", w_pa, 32'h5A5A5001);
        chk("R9", "no fill on probe", {31'b0, w_fill}, 32'd0);
    endtask

    task automatic t_miss();
        logic [31:0] g1;
        mem.delete();
        g1 = grp(VA, PA_, MASK, BASE, 0);
        put_word(g1, tagw(1, VA ^ 24'h000100, 0, AA));
        walk(VA, PA_, AA, 2'd2, 12'h000, BASE, MASK, 0);
        chk("R8", "fault on miss", {31'b0, w_fault}, 32'd1);
        chk("R8", "16 tag reads", rd_cnt, 16);
        chk("R8", "no write on miss", wr_cnt, 0);
        chk("R9", "no fill on miss", {31'b0, w_fill}, 32'd0);
    endtask

    task automatic t_fetch_invalid();
        logic [31:0] g;
        mem.delete();
        g = grp(VA, PA_, MASK, BASE, 0);
        put_word(g, tagw(0, VA, 0, AA));
        put_word(g + 4, mapw(20'hDEAD0, 0, 0, 2'b00));
        put_word(g + 8, tagw(1, VA, 0, AA));
        put_word(g + 12, mapw(20'h0BEEF, 0, 0, 2'b11));
        walk(VA, PA_, AA, 2'd3, 12'h777, BASE, MASK, 0);
        chk("R4", "invalid entry skipped", w_pa, 32'h0BEEF777);
        chk("R4", "reads to slot 1", rd_cnt, 3);
        chk("R5", "fetch sets R only", w_pte, mapw(20'h0BEEF, 1, 0, 2'b11));
    endtask

    task automatic t_last_slot_slow();
        logic [23:0] v;
        logic [31:0] b, g2;
        logic [18:0] m;
        v = 24'hFFF00F; b = 32'h0800_0000; m = 19'h0000F;
        mem.delete();
        lat = 3;
        g2 = grp(v, 16'hFFFF, m, b, 1);
        put_word(g2 + 56, tagw(1, v, 1, 6'h3F));
        put_word(g2 + 60, mapw(20'hFEDCB, 0, 1, 2'b00));
        walk(v, 16'hFFFF, 6'h3F, 2'd1, 12'hFFF, b, m, 0);
        lat = 0;
        chk("R2", "last secondary slot with narrow mask", w_pa, 32'hFEDCBFFF);
        chk("R2", "reads for last slot", rd_cnt, 17);
        chk("R11", "single write with latency", wr_cnt, 1);
        chk("R5", "read keeps C", w_pte, mapw(20'hFEDCB, 1, 1, 2'b00));
    endtask

    task automatic t_busy_ignore();
        setup_primary();
        walk(VA, PA_, AA, 2'd1, 12'h456, BASE, MASK, 1);
        chk("R10", "req_ready low while busy", ready_seen, 0);
        chk("R10", "first request result kept", w_pa, 32'h5A5A5456);
        chk("R10", "no extra walk reads", rd_cnt, 5);
        repeat (3) @(negedge clk);
        chk("R10", "idle after walk", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_primary_read();
        t_secondary_write();
        t_probe();
        t_miss();
        t_fetch_invalid();
        t_last_slot_slow();
        t_busy_ignore();
        summary();
        $finish;
    end
endmodule